// File: doc/BRIEF.md
# Prescaled Match Timer with PWM

This block is a free-running counter that is stepped by a programmable prescaler. Several compare channels watch it. When the count reaches a channel's compare value, the channel can take any combination of four actions: restart the count, halt the count, latch an interrupt flag, or change its own external output. The output change is one of leave, force low, force high or invert.

The lower channels can instead run as pulse-width modulators. The last channel then acts as the shared period register: it restarts the count when the count reaches its value. Software uses a simple register write/read port. A pulse width can be changed at any time by rewriting a channel's compare value while the counter runs.

Top module: `mtc_top`

## Requirements
- R1: After reset the count reads 0, every output and `irq` are low, the flag register (address 3) and the control register (address 0) read 0, and every compare register (addresses 4..7) reads all ones.
- R2: While control bit 0 (run) is set, the count advances by one once every P+1 clocks, where P is the prescale register at address 1. The count reads back at address 2 and never moves while run is clear.
- R3: While control bit 1 is set, the count and the prescaler are held at zero.
- R4: Channel configuration registers sit at addresses 8..11. On a match event, bits [4:3] select the output action: 0 leave, 1 low, 2 high, 3 invert. The action is applied once per event and not again while the count rests at that value.
- R5: Writing a channel's configuration register loads that channel's output with configuration bit 5.
- R6: If configuration bit 2 is set, a match clears control bit 0 in the same cycle, and the count holds at the compare value.
- R7: If configuration bit 1 is set, a match makes the next prescaled step load 0 instead of incrementing, so a compare value M gives a period of M+1 steps.
- R8: If configuration bit 0 is set, a match sets flag bit i of channel i. `irq` is the OR of all flags. A channel with bit 0 clear never sets its flag.
- R9: Writing a 1 to a bit of the flag register clears that flag. Writing a 0 leaves the flag unchanged.
- R10: Configuration bit 6 on channels 0..2 selects PWM. The output goes low on the step where the count restarts and goes high on the step after the count equals the channel's compare value. A compare value rewritten while the counter runs changes the pulse width.
- R11: Configuration bit 6 has no effect on channel 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| matchOut | output | 4 | External match outputs, one per channel |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The hardest state to reach is steady-state PWM: a shared period restart and a pulse edge interleave every few clocks. The stimulus programs a short period with no prescaling and lets the counter wrap several times. It then counts the high cycles of the output over a window that is a whole number of periods, so the result does not depend on phase. The compare value is then rewritten while running, and the new duty is counted the same way. Repeated toggling while the count rests is covered by combining stop-on-match with the invert action, so any second action would show at the output.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int CFGW = 7;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_PRESC = 1;
  localparam int ADDR_COUNT = 2;
  localparam int ADDR_FLAGS = 3;
  localparam int ADDR_MATCH = 4;

  // channel configuration, MSB first: pwm[6] init[5] act[4:3] stop[2] rst[1] irqEn[0]
  typedef struct packed {
    logic       pwm;
    logic       init;
    logic [1:0] act;
    logic       stop;
    logic       rst;
    logic       irqEn;
  } chanCfg_t;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_INV  = 2'd3
  } outAct_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic countEn;
    logic countClr;
    logic wrapReq;
  } strobes_t;
endpackage

// File: rtl/mtc_datapath.sv
module mtc_datapath
  import mtc_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic             wrPresc,
  input  logic [NCH-1:0]   wrMatch,
  input  logic [W-1:0]     wrData,
  output logic [W-1:0]     count,
  output logic [W-1:0]     presc,
  output logic [NCH*W-1:0] matchFlat,
  output logic [NCH-1:0]   evt,
  output logic             wrapped
);
  logic [W-1:0] prescCnt;
  logic         pending;
  logic         newValue;
  logic         tick;

  assign tick    = stb.countEn && (prescCnt >= presc);
  assign wrapped = tick && (pending || stb.wrapReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
      count    <= '0;
      pending  <= 1'b0;
      newValue <= 1'b0;
    end else if (stb.countClr) begin
      prescCnt <= '0;
      count    <= '0;
      pending  <= 1'b0;
      newValue <= 1'b0;
    end else begin
      newValue <= tick;
      if (stb.countEn) prescCnt <= tick ? '0 : prescCnt + 1'b1;
      if (tick) begin
        count   <= wrapped ? '0 : count + 1'b1;
        pending <= 1'b0;
      end else begin
        pending <= pending || stb.wrapReq;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        presc <= '0;
    else if (wrPresc) presc <= wrData;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_match
    logic [W-1:0] matchReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           matchReg <= '1;
      else if (wrMatch[i]) matchReg <= wrData;
    end
    assign matchFlat[i*W +: W] = matchReg;
    // an event only on the cycle the count has just taken a new value
    assign evt[i] = newValue && (count == matchReg);
  end
endmodule

// File: rtl/mtc_control.sv
module mtc_control
  import mtc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [CFGW-1:0]     wrByte,
  input  logic [NCH-1:0]      evt,
  input  logic                wrapped,
  output strobes_t            stb,
  output logic                wrPresc,
  output logic [NCH-1:0]      wrMatch,
  output logic [NCH*CFGW-1:0] cfgFlat,
  output logic [NCH-1:0]      flags,
  output logic [NCH-1:0]      matchOut,
  output logic                runBit,
  output logic                clrBit,
  output logic                stopHit
);
  localparam int CFG_BASE = ADDR_MATCH + NCH;

  logic           wrCtrl, wrFlags;
  logic [NCH-1:0] wrCfg, stopVec, rstVec, setVec;
  chanCfg_t       cfg [NCH];

  assign wrCtrl  = wrEn && (wrAddr == AW'(ADDR_CTRL));
  assign wrPresc = wrEn && (wrAddr == AW'(ADDR_PRESC));
  assign wrFlags = wrEn && (wrAddr == AW'(ADDR_FLAGS));

  assign stopHit     = |stopVec;
  assign stb.countClr = clrBit;
  assign stb.countEn  = runBit && !stopHit && !clrBit;
  assign stb.wrapReq  = |rstVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit <= 1'b0;
      clrBit <= 1'b0;
    end else if (wrCtrl) begin
      runBit <= wrByte[0];
      clrBit <= wrByte[1];
    end else if (stopHit) begin
      runBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~(wrFlags ? wrByte[NCH-1:0] : '0)) | setVec;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam bit PWM_OK = (i < NCH - 1);
    logic pwmOn;

    assign wrMatch[i] = wrEn && (wrAddr == AW'(ADDR_MATCH + i));
    assign wrCfg[i]   = wrEn && (wrAddr == AW'(CFG_BASE + i));
    assign stopVec[i] = evt[i] && cfg[i].stop;
    assign rstVec[i]  = evt[i] && cfg[i].rst;
    assign setVec[i]  = evt[i] && cfg[i].irqEn;
    assign pwmOn      = PWM_OK && cfg[i].pwm;
    assign cfgFlat[i*CFGW +: CFGW] = cfg[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfg[i]      <= '0;
        matchOut[i] <= 1'b0;
      end else if (wrCfg[i]) begin
        cfg[i]      <= chanCfg_t'(wrByte);
        matchOut[i] <= wrByte[5];
      end else if (pwmOn) begin
        if (wrapped)     matchOut[i] <= 1'b0;
        else if (evt[i]) matchOut[i] <= 1'b1;
      end else if (evt[i]) begin
        case (outAct_e'(cfg[i].act))
          ACT_LOW:  matchOut[i] <= 1'b0;
          ACT_HIGH: matchOut[i] <= 1'b1;
          ACT_INV:  matchOut[i] <= !matchOut[i];
          default:  matchOut[i] <= matchOut[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/mtc_top.sv
module mtc_top
  import mtc_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [AW-1:0]  wrAddr,
  input  logic [W-1:0]   wrData,
  input  logic [AW-1:0]  rdAddr,
  output logic [W-1:0]   rdData,
  output logic [NCH-1:0] matchOut,
  output logic           irq
);
  strobes_t            stb;
  logic                wrPresc, wrapped, runBit, clrBit, stopHit;
  logic [NCH-1:0]      wrMatch, evt, flags;
  logic [W-1:0]        count, presc;
  logic [NCH*W-1:0]    matchFlat;
  logic [NCH*CFGW-1:0] cfgFlat;

  mtc_control #(.NCH(NCH), .AW(AW)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrData[CFGW-1:0]),
    .evt(evt), .wrapped(wrapped), .stb(stb), .wrPresc(wrPresc), .wrMatch(wrMatch),
    .cfgFlat(cfgFlat), .flags(flags), .matchOut(matchOut), .runBit(runBit),
    .clrBit(clrBit), .stopHit(stopHit)
  );

  mtc_datapath #(.W(W), .NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrPresc(wrPresc), .wrMatch(wrMatch),
    .wrData(wrData), .count(count), .presc(presc), .matchFlat(matchFlat),
    .evt(evt), .wrapped(wrapped)
  );

  assign irq = |flags;

  always_comb begin
    rdData = '0;
    if (rdAddr == AW'(ADDR_CTRL))       rdData = W'({clrBit, runBit});
    else if (rdAddr == AW'(ADDR_PRESC)) rdData = presc;
    else if (rdAddr == AW'(ADDR_COUNT)) rdData = count;
    else if (rdAddr == AW'(ADDR_FLAGS)) rdData = W'(flags);
    for (int i = 0; i < NCH; i++) begin
      if (rdAddr == AW'(ADDR_MATCH + i))       rdData = matchFlat[i*W +: W];
      if (rdAddr == AW'(ADDR_MATCH + NCH + i)) rdData = W'(cfgFlat[i*CFGW +: CFGW]);
    end
  end
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
  parameter int W   = 32,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rstN,
  input logic [W-1:0]   count,
  input logic           countEn,
  input logic           clrBit,
  input logic           runBit,
  input logic           stopHit,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] evt,
  input logic           wrEn,
  input logic [AW-1:0]  wrAddr,
  input logic [W-1:0]   wrData
);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !clrBit) |=> $stable(count));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));

  // R6
  stop_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopHit && !wrEn) |=> !runBit);

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(flags & ~$past(flags))) |-> $past(|evt));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == AW'(3) && wrData[NCH-1:0] == '1 && evt == '0) |=> (flags == '0));
endmodule

bind mtc_top mtc_checker #(.W(W), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .count(count), .countEn(stb.countEn), .clrBit(clrBit),
  .runBit(runBit), .stopHit(stopHit), .flags(flags), .evt(evt),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/test_mtc_top.sv
module test_mtc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  matchOut;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtc_top i_mtc_top (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
                     .rdAddr(rdAddr), .rdData(rdData), .matchOut(matchOut), .irq(irq));

  // {action[1:0], init, expected output}
  localparam logic [3:0] VEC [5] = '{4'b00_1_1, 4'b01_1_0, 4'b10_0_1, 4'b11_0_1, 4'b11_1_0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic countHigh(input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (matchOut[0]) h++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2, v); check("R1 count", v, 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(3, v); check("R1 flags", v, 0);
    rd(5, v); check("R1 match", v, 32'hFFFF_FFFF);
    check("R1 outputs", {28'd0, matchOut}, 0);
    check("R1 irq", irq, 0);

    // R2 prescale 3: 40 running clocks give 10 steps
    wr(1, 3);
    wr(0, 1);
    repeat (39) @(negedge clk);
    wr(0, 0);
    rd(2, v); check("R2 prescaled count", v, 10);
    repeat (5) @(negedge clk);
    rd(2, v); check("R2 hold when stopped", v, 10);

    // R3 clear holds count at zero
    wr(0, 3);
    repeat (6) @(negedge clk);
    rd(2, v); check("R3 clear hold", v, 0);

    // R4 R5 R6 action table, ch0 stops at 3
    wr(1, 0);
    wr(4, 3);
    for (int e = 0; e < 5; e++) begin
      wr(0, 2);
      wr(8, 32'h4 | (32'(VEC[e][3:2]) << 3) | (32'(VEC[e][1]) << 5));
      check("R5 init level", matchOut[0], VEC[e][1]);
      wr(0, 1);
      repeat (10) @(negedge clk);
      check("R4 action result", matchOut[0], VEC[e][0]);
      rd(2, v); check("R6 count held", v, 3);
      rd(0, v); check("R6 run cleared", v, 0);
    end
    rd(3, v); check("R8 no flag without enable", v, 0);

    // R7 R10 R11 PWM: period 5 steps, ch0 width via compare
    wr(0, 2);
    wr(7, 4);
    wr(4, 2);
    wr(11, 32'h40 | 32'h20 | 32'h2 | 32'h1);
    wr(8, 32'h40);
    wr(0, 1);
    repeat (20) @(negedge clk);
    countHigh(50, h); check("R7 R10 duty at compare 2", h, 20);
    check("R11 ch3 ignores pwm", matchOut[3], 1);
    wr(4, 0);
    repeat (10) @(negedge clk);
    countHigh(50, h); check("R10 duty after rewrite", h, 40);
    rd(3, v); check("R8 flag of ch3 only", v, 8);
    check("R8 irq", irq, 1);
    wr(0, 0);
    wr(3, 4);
    rd(3, v); check("R9 write zero keeps flag", v, 8);
    wr(3, 8);
    rd(3, v); check("R9 flag cleared", v, 0);
    check("R9 irq low", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule